// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block keeps a small, fully associative set of page-table entries and translates a 32-bit virtual address into a 32-bit physical address in the same cycle the lookup is presented. Pages are 4 KiB. The upper 20 bits select the page and are replaced by the stored frame number. The lower 12 bits pass through untouched. Each entry is tagged with an address-space identifier, so entries belonging to different processes can live side by side without a flush on every context switch. An entry flagged global matches under any identifier.

Each entry carries separate read and write permissions. A lookup that finds its page but asks for an access the entry forbids reports a protection fault instead of a translation. A lookup that finds nothing reports a miss, and software walks the page tables itself. Software then installs the entry through a write port, either at a slot it names or at a pseudo-random slot produced by a free-running shift register. A read port lets software inspect any slot, including the used bit that any hit sets and the dirty bit that a write hit sets. A flush input invalidates every entry in one cycle.

Top module: `tlb_sw_refill`

## Requirements
- R1: On a hit, `lk_paddr` equals the entry's 20-bit frame number in bits 31:12 and `lk_vaddr[11:0]` in bits 11:0, in the same cycle as the lookup.
- R2: An entry matches only when it is valid, its page number equals `lk_vaddr[31:12]`, and either its identifier equals `cur_asid` or its global flag is 1.
- R3: A read lookup (`lk_write`=0) needs the entry's read permission, and a write lookup (`lk_write`=1) needs its write permission. A matching entry without the needed permission gives `lk_fault`=1 and `lk_paddr`=0.
- R4: When `lk_valid` is 1, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is 1, and `lk_miss` is 1 when no entry matches. When `lk_valid` is 0, all three outputs and `lk_paddr` are 0.
- R5: With `wr_en`=1 and `flush`=0, the entry is written at the next rising edge with its dirty and used bits cleared. The slot is `wr_index` when `wr_random`=0, and the current `rand_slot` when `wr_random`=1.
- R6: `rand_slot` equals L XOR {000,P}. L is a 4-bit register that resets to 0001 and steps every cycle to {L[2:0], L[3]^L[2]}, so it never reaches zero. P is a bit that resets to 0 and toggles every cycle. Over any 30 consecutive cycles, all 16 slots are produced.
- R7: A hit sets the entry's used bit at the next edge, and a write hit also sets its dirty bit. A miss or a fault changes neither bit.
- R8: `flush`=1 clears every valid bit at the next edge. A write requested in the same cycle is dropped.
- R9: After reset, no entry is valid, and every lookup misses.
- R10: When several entries match, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| cur_asid | input | 8 | Current address-space identifier |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry forbids the access |
| lk_paddr | output | 32 | Physical address on a hit, else 0 |
| wr_en | input | 1 | Install an entry |
| wr_random | input | 1 | Use the random slot instead of wr_index |
| wr_index | input | 4 | Explicit slot for the install |
| wr_vpn | input | 20 | Page number of the new entry |
| wr_asid | input | 8 | Identifier of the new entry |
| wr_pfn | input | 20 | Frame number of the new entry |
| wr_global | input | 1 | New entry ignores the identifier |
| wr_can_read | input | 1 | New entry allows reads |
| wr_can_write | input | 1 | New entry allows writes |
| rand_slot | output | 4 | Slot a random install would use this cycle |
| rd_index | input | 4 | Slot to inspect |
| rd_valid | output | 1 | Inspected slot valid bit |
| rd_vpn | output | 20 | Inspected slot page number |
| rd_asid | output | 8 | Inspected slot identifier |
| rd_pfn | output | 20 | Inspected slot frame number |
| rd_global | output | 1 | Inspected slot global flag |
| rd_can_read | output | 1 | Inspected slot read permission |
| rd_can_write | output | 1 | Inspected slot write permission |
| rd_dirty | output | 1 | Inspected slot dirty bit |
| rd_used | output | 1 | Inspected slot used bit |

## Verification
The bench installs two entries that share a page number but differ in identifier. It expects each one to answer only under its own identifier. A design that ignored the identifier would return the wrong frame, and one that ignored the global flag would miss the shared page. Read-only and write-only entries are probed with both access kinds. A swapped permission check would translate where a fault is due. An entry that only ever faulted must keep clear used and dirty bits. Two overlapping global entries must resolve to the lower slot. A flush that arrives together with a write must leave no valid entry, and a design that let the write win would still hit. The random slot sequence is compared cycle by cycle against the stated recurrence and must cover all sixteen slots. A stuck or zero-locked register would fail both checks.

// File: rtl/tlb_sw_refill.sv
module tlb_sw_refill #(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ASID_W    = 8,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int VPN_W    = VA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lk_valid,
  input  logic              lk_write,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [VA_W-1:0]   lk_paddr,
  input  logic              wr_en,
  input  logic              wr_random,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_pfn,
  input  logic              wr_global,
  input  logic              wr_can_read,
  input  logic              wr_can_write,
  output logic [IDX_W-1:0]  rand_slot,
  input  logic [IDX_W-1:0]  rd_index,
  output logic              rd_valid,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [ASID_W-1:0] rd_asid,
  output logic [VPN_W-1:0]  rd_pfn,
  output logic              rd_global,
  output logic              rd_can_read,
  output logic              rd_can_write,
  output logic              rd_dirty,
  output logic              rd_used
);

  logic [ENTRIES-1:0] v_q, g_q, pr_q, pw_q, d_q, u_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [VPN_W-1:0]   pfn_q [ENTRIES];
  logic [ASID_W-1:0]  asid_q[ENTRIES];

  logic [3:0]         lfsr_q;
  logic               phase_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   sel;
  logic               any;
  logic               perm_ok;
  logic [IDX_W-1:0]   ws;
  logic               do_wr;

  assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = v_q[i] && (vpn_q[i] == lk_vpn) &&
                      (g_q[i] || (asid_q[i] == cur_asid));
  end

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        any = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign perm_ok  = lk_write ? pw_q[sel] : pr_q[sel];
  assign lk_hit   = lk_valid && any && perm_ok;
  assign lk_fault = lk_valid && any && !perm_ok;
  assign lk_miss  = lk_valid && !any;
  assign lk_paddr = lk_hit ? {pfn_q[sel], lk_vaddr[PAGE_BITS-1:0]} : '0;

  assign rand_slot = IDX_W'({28'd0, lfsr_q ^ {3'b000, phase_q}} % ENTRIES);
  assign ws        = wr_random ? rand_slot : wr_index;
  assign do_wr     = wr_en && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= 4'b0001;
      phase_q <= 1'b0;
    end else begin
      lfsr_q  <= {lfsr_q[2:0], lfsr_q[3] ^ lfsr_q[2]};
      phase_q <= !phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      g_q  <= '0;
      pr_q <= '0;
      pw_q <= '0;
      d_q  <= '0;
      u_q  <= '0;
    end else begin
      if (lk_hit) begin
        u_q[sel] <= 1'b1;
        if (lk_write) d_q[sel] <= 1'b1;
      end
      if (flush) begin
        v_q <= '0;
      end else if (wr_en) begin
        v_q[ws]  <= 1'b1;
        g_q[ws]  <= wr_global;
        pr_q[ws] <= wr_can_read;
        pw_q[ws] <= wr_can_write;
        d_q[ws]  <= 1'b0;
        u_q[ws]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      vpn_q[ws]  <= wr_vpn;
      pfn_q[ws]  <= wr_pfn;
      asid_q[ws] <= wr_asid;
    end
  end

  assign rd_valid     = v_q[rd_index];
  assign rd_vpn       = vpn_q[rd_index];
  assign rd_asid      = asid_q[rd_index];
  assign rd_pfn       = pfn_q[rd_index];
  assign rd_global    = g_q[rd_index];
  assign rd_can_read  = pr_q[rd_index];
  assign rd_can_write = pw_q[rd_index];
  assign rd_dirty     = d_q[rd_index];
  assign rd_used      = u_q[rd_index];

endmodule

// File: rtl/tlb_sw_refill_chk.sv
module tlb_sw_refill_chk #(
  parameter int IDX_W     = 4,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int VPN_W     = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_fault,
  input logic [VA_W-1:0]  lk_paddr,
  input logic             wr_en,
  input logic             wr_random,
  input logic [IDX_W-1:0] wr_index,
  input logic [VPN_W-1:0] wr_vpn,
  input logic [IDX_W-1:0] rd_index,
  input logic             rd_valid,
  input logic [VPN_W-1:0] rd_vpn,
  input logic             rd_dirty,
  input logic             rd_used,
  input logic [3:0]       lfsr_q
);

  // R4
  out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lk_hit, lk_miss, lk_fault}) == (lk_valid ? 1 : 0));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> lk_paddr == '0);

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

  // R3
  fault_nopa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_paddr == '0);

  // R8
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit && !lk_fault);

  // R5
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !flush && !wr_random |=>
      (rd_index != $past(wr_index)) ||
      (rd_valid && rd_vpn == $past(wr_vpn) && !rd_dirty && !rd_used));

  // R6
  lfsr_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 4'd0);

endmodule

bind tlb_sw_refill tlb_sw_refill_chk #(
  .IDX_W(IDX_W), .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .VPN_W(VPN_W)
) u_chk (.*);

// File: tb/tlb_sw_refill_bench.sv
module tlb_sw_refill_bench;
  logic        clk = 0, rst_n = 0, flush = 0;
  logic [7:0]  cur_asid = 0;
  logic        lk_valid = 0, lk_write = 0;
  logic [31:0] lk_vaddr = 0;
  logic        lk_hit, lk_miss, lk_fault;
  logic [31:0] lk_paddr;
  logic        wr_en = 0, wr_random = 0;
  logic [3:0]  wr_index = 0;
  logic [19:0] wr_vpn = 0, wr_pfn = 0;
  logic [7:0]  wr_asid = 0;
  logic        wr_global = 0, wr_can_read = 0, wr_can_write = 0;
  logic [3:0]  rand_slot;
  logic [3:0]  rd_index = 0;
  logic        rd_valid, rd_global, rd_can_read, rd_can_write, rd_dirty, rd_used;
  logic [19:0] rd_vpn, rd_pfn;
  logic [7:0]  rd_asid;

  int n_chk = 0, n_err = 0;
  logic [3:0] m_l;
  logic       m_p;

  always #10 clk = ~clk;

  tlb_sw_refill u_tlb_sw_refill (.*);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_l <= 4'b0001; m_p <= 1'b0; end
    else begin m_l <= {m_l[2:0], m_l[3] ^ m_l[2]}; m_p <= ~m_p; end

  // asid, vaddr, write, {hit,miss,fault}, paddr
  localparam logic [75:0] VEC [9] = '{
    {8'd5, 32'h12345678, 1'b0, 3'b100, 32'hABCDE678},
    {8'd9, 32'h12345FFF, 1'b1, 3'b100, 32'h55555FFF},
    {8'd3, 32'h12345000, 1'b0, 3'b010, 32'h00000000},
    {8'd3, 32'h00042ABC, 1'b0, 3'b100, 32'h00100ABC},
    {8'd7, 32'h00042001, 1'b1, 3'b001, 32'h00000000},
    {8'd5, 32'h0FFFF010, 1'b0, 3'b001, 32'h00000000},
    {8'd5, 32'h0FFFF010, 1'b1, 3'b100, 32'h11111010},
    {8'd5, 32'h99999000, 1'b0, 3'b010, 32'h00000000},
    {8'd5, 32'h00777123, 1'b1, 3'b001, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic install(input logic rnd, input logic [3:0] idx, input logic [19:0] vpn,
                         input logic [7:0] asid, input logic [19:0] pfn,
                         input logic g, input logic r, input logic w);
    wr_en = 1; wr_random = rnd; wr_index = idx; wr_vpn = vpn; wr_asid = asid;
    wr_pfn = pfn; wr_global = g; wr_can_read = r; wr_can_write = w;
    @(negedge clk);
    wr_en = 0; wr_random = 0;
  endtask

  task automatic look(input logic [7:0] asid, input logic [31:0] va, input logic w);
    lk_valid = 1; cur_asid = asid; lk_vaddr = va; lk_write = w;
    #5;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [3:0]  slot;
    logic [15:0] seen;
    logic        anyv;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #5;
    chk("R6 reset slot", {28'd0, rand_slot}, 32'd1);
    anyv = 0;
    for (int i = 0; i < 16; i++) begin rd_index = 4'(i); #0.1; anyv |= rd_valid; end
    chk("R9 no valid after reset", {31'd0, anyv}, 32'd0);
    look(8'd5, 32'h12345678, 1'b0);
    chk("R9 lookup misses after reset", {29'd0, lk_hit, lk_miss, lk_fault}, 32'b010);
    @(negedge clk); lk_valid = 0;

    install(0, 4'd0, 20'h12345, 8'd5, 20'hABCDE, 0, 1, 1);
    install(0, 4'd1, 20'h00042, 8'd7, 20'h00100, 1, 1, 0);
    install(0, 4'd2, 20'h12345, 8'd9, 20'h55555, 0, 1, 1);
    install(0, 4'd3, 20'h0FFFF, 8'd5, 20'h11111, 0, 0, 1);
    install(0, 4'd4, 20'h00777, 8'd5, 20'h22222, 0, 1, 0);

    for (int k = 0; k < 9; k++) begin
      look(VEC[k][75:68], VEC[k][67:36], VEC[k][35]);
      chk($sformatf("R2 R3 R4 vec%0d status", k), {29'd0, lk_hit, lk_miss, lk_fault},
          {29'd0, VEC[k][34:32]});
      chk($sformatf("R1 vec%0d paddr", k), lk_paddr, VEC[k][31:0]);
      @(negedge clk);
    end
    lk_valid = 0;
    #5;
    chk("R4 idle outputs", {lk_hit, lk_miss, lk_fault, lk_paddr[28:0]}, 32'd0);

    rd_index = 0; #1; chk("R7 e0 used/dirty", {30'd0, rd_used, rd_dirty}, 32'b10);
    rd_index = 1; #1; chk("R7 e1 used/dirty", {30'd0, rd_used, rd_dirty}, 32'b10);
    rd_index = 2; #1; chk("R7 e2 used/dirty", {30'd0, rd_used, rd_dirty}, 32'b11);
    rd_index = 3; #1; chk("R7 e3 used/dirty", {30'd0, rd_used, rd_dirty}, 32'b11);
    rd_index = 4; #1; chk("R7 fault-only e4 untouched", {30'd0, rd_used, rd_dirty}, 32'b00);
    rd_index = 1; #1; chk("R5 e1 fields", {rd_pfn, rd_asid, 1'b0, rd_global, rd_can_read, rd_can_write},
                          {20'h00100, 8'd7, 4'b0110});
    @(negedge clk);

    install(0, 4'd6, 20'h33333, 8'd0, 20'h00006, 1, 1, 1);
    install(0, 4'd5, 20'h33333, 8'd0, 20'h00005, 1, 1, 1);
    look(8'd42, 32'h33333444, 1'b0);
    chk("R10 lowest slot wins", lk_paddr, 32'h00005444);
    @(negedge clk); lk_valid = 0;

    #1;
    chk("R6 slot matches recurrence", {28'd0, rand_slot}, {28'd0, m_l ^ {3'b000, m_p}});
    slot = m_l ^ {3'b000, m_p};
    install(1, 4'd0, 20'h77777, 8'd1, 20'h0BEEF, 0, 1, 1);
    rd_index = slot; #1;
    chk("R5 random install slot", {11'd0, rd_valid, rd_vpn}, {12'd1, 20'h77777});
    look(8'd1, 32'h77777ABC, 1'b1);
    chk("R5 random entry hit", lk_paddr, 32'h0BEEFABC);
    @(negedge clk); lk_valid = 0;

    seen = 0;
    for (int c = 0; c < 30; c++) begin
      #1;
      if (rand_slot !== (m_l ^ {3'b000, m_p})) begin
        chk("R6 sequence", {28'd0, rand_slot}, {28'd0, m_l ^ {3'b000, m_p}});
      end
      seen[rand_slot] = 1'b1;
      @(negedge clk);
    end
    chk("R6 all slots covered", {16'd0, seen}, 32'h0000FFFF);

    flush = 1;
    install(0, 4'd10, 20'h44444, 8'd5, 20'h00044, 0, 1, 1);
    flush = 0;
    anyv = 0;
    for (int i = 0; i < 16; i++) begin rd_index = 4'(i); #0.1; anyv |= rd_valid; end
    chk("R8 flush clears all", {31'd0, anyv}, 32'd0);
    look(8'd5, 32'h12345678, 1'b0);
    chk("R8 miss after flush", {29'd0, lk_hit, lk_miss, lk_fault}, 32'b010);
    look(8'd5, 32'h44444000, 1'b0);
    chk("R8 write during flush dropped", {29'd0, lk_hit, lk_miss, lk_fault}, 32'b010);
    @(negedge clk); lk_valid = 0;

    finish_run();
  end
endmodule